// File: doc/BRIEF.md
# Triggered Conversion Command Queue Sequencer

This block sits between a set of command queues and a small group of converter targets. Software or a DMA engine loads 32-bit command words into per-queue FIFOs. Each queue is started by an external trigger pulse. While a queue is running, its commands go out one at a time on a single transmit channel to the target named inside each command. A queue stops after it sends a command with the pause flag set and waits for the next trigger. It stops for good after it sends a command with the end-of-queue flag set, and stays stopped until a re-arm pulse returns it to idle.

Only one command is outstanding at a time. A conversion command is finished when its 16-bit result comes back. The block then writes that result into the result FIFO named by the command's tag field, whatever queue issued the command. A configuration command returns no result, and the channel is free as soon as the command is accepted. A tag that names no existing result FIFO causes the result to be thrown away and sets a sticky error flag. The end-of-queue flags are also sticky. Both kinds of flag are cleared by write-one-to-clear inputs. Any set end-of-queue flag raises the interrupt request.

Command word: bit 31 end-of-queue, bit 30 pause, bits 29:28 target, bits 27:24 result tag, bit 23 conversion request (1) or configuration write (0), bits 22:0 free payload.

Top module: `cq_sequencer`

## Requirements
- R1: After reset no command is offered (tx_valid low), res_ready is low, every end-of-queue flag, the interrupt and the tag error flag are low, and every result FIFO is empty.
- R2: A triggered queue with queued commands offers them on tx_data exactly as written, with tx_target equal to bits 29:28. The word is held stable until tx_ready is seen.
- R3: Once a command with bit 30 set has been accepted, its queue sends nothing more until another trigger, and then it continues with the following command.
- R4: A trigger that arrives while a queue is already running has no effect. The run continues and still stops at the next pause-flagged command.
- R5: Once a command with bit 31 set has been accepted, eoq_flag for its queue is set and eoq_irq goes high. The queue then ignores triggers.
- R6: A rearm pulse returns an ended queue to idle, and a later trigger restarts it from its next stored command.
- R7: Among queues that are running and non-empty, the lowest-numbered queue gets the next transfer slot, and it keeps the slot command after command until it pauses or ends.
- R8: While a conversion result is still outstanding, no other command is offered, even when another queue is triggered.
- R9: A conversion result (bit 23 set) is written to the result FIFO whose index equals bits 27:24 of its command. The index of the issuing queue plays no part.
- R10: A configuration command (bit 23 clear) produces no result-FIFO entry, and the channel moves on to the next command without waiting.
- R11: When a result's tag is not less than the number of result FIFOs, the result is accepted and discarded, and tag_err is set and stays set.
- R12: eoq_clr bits and err_clr clear the matching sticky flags, and eoq_irq falls once no end-of-queue flag remains set.
- R13: While the result FIFO named by the pending tag is full, res_ready stays low. It rises once an entry is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_push | input | NUM_CQ | Per-queue write strobe for cmd_wdata |
| cmd_wdata | input | 32 | Command word to store |
| cmd_full | output | NUM_CQ | Per-queue command FIFO full |
| trig | input | NUM_CQ | Per-queue trigger pulse |
| rearm | input | NUM_CQ | Per-queue return from ended to idle |
| tx_valid | output | 1 | A command is offered to the targets |
| tx_data | output | 32 | Offered command word |
| tx_target | output | 2 | Target select of the offered command |
| tx_ready | input | 1 | Target accepts the offered command |
| res_valid | input | 1 | A conversion result is presented |
| res_data | input | 16 | Conversion result |
| res_ready | output | 1 | Result is taken this cycle if res_valid |
| rq_pop | input | NUM_RQ | Per-result-FIFO read strobe |
| rq_data | output | 16*NUM_RQ | Head entry of each result FIFO, FIFO j at bits 16j+15:16j |
| rq_empty | output | NUM_RQ | Per-result-FIFO empty |
| eoq_flag | output | NUM_CQ | Sticky end-of-queue flags |
| eoq_clr | input | NUM_CQ | Write-one-to-clear for eoq_flag |
| eoq_irq | output | 1 | End-of-queue interrupt request |
| tag_err | output | 1 | Sticky invalid-tag flag |
| err_clr | input | 1 | Write-one-to-clear for tag_err |

## Verification
Some checks run on every cycle. The offered command must hold steady until it is accepted, and the channel never offers a command while it also takes a result. Grants and result-FIFO writes are at most one-hot. A bad tag never writes a FIFO and always raises the error flag. The sticky flags never drop without a clear. Other behaviour depends on a history of several transfers, and only the bench scenarios can show it. This covers the order of commands across queues, pausing and resuming at the right command, and triggers being ignored after the end of a queue. It also covers FIFO selection for every tag from every queue, and holding off a result while its FIFO is full.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int CMD_W   = 32;
  localparam int RES_W   = 16;
  localparam int TAG_W   = 4;
  localparam int TGT_W   = 2;
  localparam int B_EOQ   = 31;
  localparam int B_PAUSE = 30;
  localparam int B_TGT   = 28;
  localparam int B_TAG   = 24;
  localparam int B_CONV  = 23;

  typedef enum logic [1:0] {Q_IDLE, Q_RUN, Q_PAUSE, Q_END} qstate_e;
  typedef enum logic [1:0] {E_IDLE, E_SEND, E_WAIT} eng_e;

  function automatic logic cmd_eoq(input logic [CMD_W-1:0] w);
    return w[B_EOQ];
  endfunction

  function automatic logic cmd_pause(input logic [CMD_W-1:0] w);
    return w[B_PAUSE];
  endfunction

  function automatic logic cmd_conv(input logic [CMD_W-1:0] w);
    return w[B_CONV];
  endfunction

  function automatic logic [TGT_W-1:0] cmd_tgt(input logic [CMD_W-1:0] w);
    return w[B_TGT +: TGT_W];
  endfunction

  function automatic logic [TAG_W-1:0] cmd_tag(input logic [CMD_W-1:0] w);
    return w[B_TAG +: TAG_W];
  endfunction
endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW-1:0] == rp[AW-1:0]) && (wp[AW] != rp[AW]);
  assign rdata = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/cq_arbiter.sv
module cq_arbiter #(
  parameter int N = 3
) (
  input  logic         enable,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (enable && req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cq_queue_ctl.sv
module cq_queue_ctl
  import cq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic rearm,
  input  logic done,
  input  logic done_eoq,
  input  logic done_pause,
  output logic running
);
  qstate_e st;

  assign running = (st == Q_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= Q_IDLE;
    else begin
      unique case (st)
        Q_IDLE:  if (trig) st <= Q_RUN;
        Q_RUN: begin
          if (done && done_eoq)        st <= Q_END;
          else if (done && done_pause) st <= Q_PAUSE;
        end
        Q_PAUSE: if (trig) st <= Q_RUN;
        Q_END:   if (rearm) st <= Q_IDLE;
        default: st <= Q_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cq_sequencer.sv
module cq_sequencer
  import cq_pkg::*;
#(
  parameter int NUM_CQ   = 3,
  parameter int NUM_RQ   = 3,
  parameter int CQ_DEPTH = 8,
  parameter int RQ_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CQ-1:0]       cmd_push,
  input  logic [CMD_W-1:0]        cmd_wdata,
  output logic [NUM_CQ-1:0]       cmd_full,
  input  logic [NUM_CQ-1:0]       trig,
  input  logic [NUM_CQ-1:0]       rearm,
  output logic                    tx_valid,
  output logic [CMD_W-1:0]        tx_data,
  output logic [TGT_W-1:0]        tx_target,
  input  logic                    tx_ready,
  input  logic                    res_valid,
  input  logic [RES_W-1:0]        res_data,
  output logic                    res_ready,
  input  logic [NUM_RQ-1:0]       rq_pop,
  output logic [NUM_RQ*RES_W-1:0] rq_data,
  output logic [NUM_RQ-1:0]       rq_empty,
  output logic [NUM_CQ-1:0]       eoq_flag,
  input  logic [NUM_CQ-1:0]       eoq_clr,
  output logic                    eoq_irq,
  output logic                    tag_err,
  input  logic                    err_clr
);
  localparam int QW = (NUM_CQ > 1) ? $clog2(NUM_CQ) : 1;

  // internal events, named for the checker
  logic [NUM_CQ-1:0] cq_empty, run, req, grant, done;
  logic [NUM_RQ-1:0] rq_full, rq_push;
  logic              xfer_done, res_accept, tag_bad, tgt_full;

  logic [CMD_W-1:0]  cq_rdata [NUM_CQ];
  logic [CMD_W-1:0]  cur_cmd;
  logic [QW-1:0]     cur_q, grant_idx;
  logic [TAG_W-1:0]  cur_tag;
  eng_e              eng_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CQ; gi++) begin : g_cq
      cq_fifo #(.W(CMD_W), .DEPTH(CQ_DEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n), .push(cmd_push[gi]), .wdata(cmd_wdata),
        .pop(grant[gi]), .rdata(cq_rdata[gi]), .empty(cq_empty[gi]),
        .full(cmd_full[gi]));
      cq_queue_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .trig(trig[gi]), .rearm(rearm[gi]),
        .done(done[gi]), .done_eoq(cmd_eoq(cur_cmd)),
        .done_pause(cmd_pause(cur_cmd)), .running(run[gi]));
      assign req[gi] = run[gi] & ~cq_empty[gi];
    end
  endgenerate

  cq_arbiter #(.N(NUM_CQ)) u_arb (
    .enable(eng_q == E_IDLE), .req(req), .grant(grant));

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < NUM_CQ; i++)
      if (grant[i]) grant_idx = QW'(i);
  end

  assign cur_tag = cmd_tag(cur_cmd);
  assign tag_bad = int'(cur_tag) >= NUM_RQ;

  always_comb begin
    tgt_full = 1'b0;
    for (int j = 0; j < NUM_RQ; j++)
      if (int'(cur_tag) == j) tgt_full = rq_full[j];
  end

  assign tx_valid   = (eng_q == E_SEND);
  assign tx_data    = cur_cmd;
  assign tx_target  = cmd_tgt(cur_cmd);
  assign xfer_done  = tx_valid & tx_ready;
  assign done       = xfer_done ? (NUM_CQ'(1) << cur_q) : '0;
  assign res_ready  = (eng_q == E_WAIT) && (tag_bad || !tgt_full);
  assign res_accept = res_valid & res_ready;

  generate
    for (gi = 0; gi < NUM_RQ; gi++) begin : g_rq
      assign rq_push[gi] = res_accept && !tag_bad && (int'(cur_tag) == gi);
      cq_fifo #(.W(RES_W), .DEPTH(RQ_DEPTH)) u_resq (
        .clk(clk), .rst_n(rst_n), .push(rq_push[gi]), .wdata(res_data),
        .pop(rq_pop[gi]), .rdata(rq_data[gi*RES_W +: RES_W]),
        .empty(rq_empty[gi]), .full(rq_full[gi]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_q   <= E_IDLE;
      cur_cmd <= '0;
      cur_q   <= '0;
    end else begin
      unique case (eng_q)
        E_IDLE: if (|grant) begin
          cur_cmd <= cq_rdata[grant_idx];
          cur_q   <= grant_idx;
          eng_q   <= E_SEND;
        end
        E_SEND: if (xfer_done) eng_q <= cmd_conv(cur_cmd) ? E_WAIT : E_IDLE;
        E_WAIT: if (res_accept) eng_q <= E_IDLE;
        default: eng_q <= E_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoq_flag <= '0;
      tag_err  <= 1'b0;
    end else begin
      eoq_flag <= (eoq_flag & ~eoq_clr) | (cmd_eoq(cur_cmd) ? done : '0);
      tag_err  <= (tag_err & ~err_clr) | (res_accept & tag_bad);
    end
  end

  assign eoq_irq = |eoq_flag;
endmodule

// File: rtl/cq_sequencer_chk.sv
module cq_sequencer_chk #(
  parameter int NUM_CQ = 3,
  parameter int NUM_RQ = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [31:0]       tx_data,
  input logic              res_ready,
  input logic [NUM_CQ-1:0] eoq_flag,
  input logic [NUM_CQ-1:0] eoq_clr,
  input logic              tag_err,
  input logic              err_clr,
  input logic [NUM_CQ-1:0] grant,
  input logic [NUM_RQ-1:0] rq_push,
  input logic              res_accept,
  input logic              tag_bad
);
  p_hold_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  p_single_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && res_ready));

  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_push_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rq_push));

  p_bad_tag_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept && tag_bad |-> rq_push == '0);

  p_bad_tag_flagged_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept && tag_bad |=> tag_err);

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tag_err && !err_clr |=> tag_err);

  p_eoq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |(eoq_flag & ~eoq_clr) |=>
      ((eoq_flag & $past(eoq_flag & ~eoq_clr)) == $past(eoq_flag & ~eoq_clr)));
endmodule

bind cq_sequencer cq_sequencer_chk #(.NUM_CQ(NUM_CQ), .NUM_RQ(NUM_RQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .res_ready(res_ready), .eoq_flag(eoq_flag),
  .eoq_clr(eoq_clr), .tag_err(tag_err), .err_clr(err_clr), .grant(grant),
  .rq_push(rq_push), .res_accept(res_accept), .tag_bad(tag_bad));

// File: tb/sim_cq_sequencer.sv
`timescale 1ns/1ps
module sim_cq_sequencer;
  localparam int NCQ = 3;
  localparam int NRQ = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCQ-1:0]    cmd_push = '0;
  logic [31:0]       cmd_wdata = '0;
  logic [NCQ-1:0]    cmd_full;
  logic [NCQ-1:0]    trig = '0;
  logic [NCQ-1:0]    rearm = '0;
  logic              tx_valid;
  logic [31:0]       tx_data;
  logic [1:0]        tx_target;
  logic              tx_ready = 1'b0;
  logic              res_valid = 1'b0;
  logic [15:0]       res_data = '0;
  logic              res_ready;
  logic [NRQ-1:0]    rq_pop = '0;
  logic [NRQ*16-1:0] rq_data;
  logic [NRQ-1:0]    rq_empty;
  logic [NCQ-1:0]    eoq_flag;
  logic [NCQ-1:0]    eoq_clr = '0;
  logic              eoq_irq;
  logic              tag_err;
  logic              err_clr = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  cq_sequencer #(.NUM_CQ(NCQ), .NUM_RQ(NRQ), .CQ_DEPTH(8), .RQ_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_wdata(cmd_wdata),
    .cmd_full(cmd_full), .trig(trig), .rearm(rearm), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_target(tx_target), .tx_ready(tx_ready),
    .res_valid(res_valid), .res_data(res_data), .res_ready(res_ready),
    .rq_pop(rq_pop), .rq_data(rq_data), .rq_empty(rq_empty),
    .eoq_flag(eoq_flag), .eoq_clr(eoq_clr), .eoq_irq(eoq_irq),
    .tag_err(tag_err), .err_clr(err_clr));

  function automatic logic [31:0] mk(input bit eoq, input bit pau,
      input int tgt, input int tag, input bit conv, input int pay);
    return {eoq, pau, 2'(tgt), 4'(tag), conv, 23'(pay)};
  endfunction

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int q, input logic [31:0] w);
    cmd_push = NCQ'(1) << q; cmd_wdata = w;
    @(negedge clk); cmd_push = '0;
  endtask

  task automatic pulse_trig(input logic [NCQ-1:0] m);
    trig = m; @(negedge clk); trig = '0;
  endtask

  task automatic pulse_rearm(input int q);
    rearm = NCQ'(1) << q; @(negedge clk); rearm = '0;
  endtask

  task automatic clr_eoq(input int q);
    eoq_clr = NCQ'(1) << q; @(negedge clk); eoq_clr = '0;
  endtask

  task automatic clr_err();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  // wait for an offered command, compare it, accept it; serve a result if asked
  task automatic take_cmd(input string req, input logic [31:0] exp,
                          input bit serve, input logic [15:0] rv);
    int n = 0;
    while (!tx_valid && n < 40) begin @(negedge clk); n++; end
    chk(req, tx_valid && tx_data == exp, tx_data, exp);
    chk("R2", tx_target == exp[29:28], tx_target, exp[29:28]);
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    if (serve) begin
      res_valid = 1'b1; res_data = rv;
      n = 0;
      while (!res_ready && n < 40) begin @(negedge clk); n++; end
      @(negedge clk); res_valid = 1'b0;
    end
  endtask

  task automatic quiet(input string req, input int cyc);
    bit seen = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (tx_valid) seen = 1;
    end
    chk(req, !seen, seen, 0);
  endtask

  task automatic pop_rq(input string req, input int j, input logic [15:0] exp);
    chk(req, !rq_empty[j] && rq_data[j*16 +: 16] == exp, rq_data[j*16 +: 16], exp);
    rq_pop = NRQ'(1) << j; @(negedge clk); rq_pop = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      chk("watchdog", 0, 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] w;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", !tx_valid && !res_ready, {tx_valid, res_ready}, 0);
    chk("R1", eoq_flag == 0 && !eoq_irq && !tag_err, {eoq_flag, eoq_irq, tag_err}, 0);
    chk("R1", rq_empty == '1, rq_empty, 7);

    // R7 priority, R10 configuration commands need no result
    push(2, mk(0, 1, 2, 0, 0, 'h22));
    push(1, mk(0, 1, 1, 0, 0, 'h11));
    push(0, mk(0, 0, 0, 0, 0, 'h01));
    push(0, mk(0, 1, 3, 0, 0, 'h02));
    pulse_trig(3'b111);
    take_cmd("R7", mk(0, 0, 0, 0, 0, 'h01), 0, 0);
    take_cmd("R7", mk(0, 1, 3, 0, 0, 'h02), 0, 0);
    take_cmd("R7", mk(0, 1, 1, 0, 0, 'h11), 0, 0);
    take_cmd("R10", mk(0, 1, 2, 0, 0, 'h22), 0, 0);
    quiet("R3", 6);
    chk("R10", rq_empty == '1 && !res_ready, rq_empty, 7);

    // R3 pause and resume, R4 trigger ignored while running
    push(0, mk(0, 0, 1, 0, 0, 'hA1));
    push(0, mk(0, 1, 2, 0, 0, 'hB2));
    push(0, mk(0, 1, 3, 0, 0, 'hC3));
    pulse_trig(3'b001);
    repeat (3) @(negedge clk);
    chk("R2", tx_valid && tx_data == mk(0, 0, 1, 0, 0, 'hA1), tx_data, mk(0, 0, 1, 0, 0, 'hA1));
    pulse_trig(3'b001);
    take_cmd("R4", mk(0, 0, 1, 0, 0, 'hA1), 0, 0);
    take_cmd("R4", mk(0, 1, 2, 0, 0, 'hB2), 0, 0);
    quiet("R4", 8);
    pulse_trig(3'b001);
    take_cmd("R3", mk(0, 1, 3, 0, 0, 'hC3), 0, 0);
    quiet("R3", 4);

    // R5 end of queue, R6 rearm, R12 clear
    push(1, mk(1, 0, 1, 0, 0, 'hD4));
    pulse_trig(3'b010);
    take_cmd("R5", mk(1, 0, 1, 0, 0, 'hD4), 0, 0);
    chk("R5", eoq_flag == 3'b010 && eoq_irq, {eoq_flag, eoq_irq}, 5);
    push(1, mk(0, 1, 0, 0, 0, 'hE5));
    pulse_trig(3'b010);
    quiet("R5", 8);
    pulse_rearm(1);
    quiet("R6", 3);
    pulse_trig(3'b010);
    take_cmd("R6", mk(0, 1, 0, 0, 0, 'hE5), 0, 0);
    clr_eoq(1);
    chk("R12", eoq_flag == 0 && !eoq_irq, {eoq_flag, eoq_irq}, 0);

    // R9 / R11 sweep: every queue against every tag value
    for (int q = 0; q < NCQ; q++) begin
      for (int t = 0; t < 16; t++) begin
        w = mk(1, 0, t % 4, t, 1, q * 100 + t);
        v = 16'(q * 256 + t * 7 + 1);
        push(q, w);
        pulse_trig(NCQ'(1) << q);
        take_cmd("R9", w, 1, v);
        chk("R5", eoq_flag == (NCQ'(1) << q), eoq_flag, NCQ'(1) << q);
        if (t < NRQ) begin
          chk("R9", tag_err == 0, tag_err, 0);
          pop_rq("R9", t, v);
          chk("R9", rq_empty == '1, rq_empty, 7);
        end else begin
          chk("R11", tag_err == 1 && rq_empty == '1, {tag_err, rq_empty}, 15);
          repeat (2) @(negedge clk);
          chk("R11", tag_err == 1, tag_err, 1);
          clr_err();
          chk("R12", tag_err == 0, tag_err, 0);
        end
        clr_eoq(q);
        pulse_rearm(q);
      end
    end

    // R13 full result FIFO holds the result off, R8 one outstanding command
    for (int k = 0; k < 5; k++) push(0, mk(k == 4, 0, 1, 1, 1, 'h300 + k));
    pulse_trig(3'b001);
    for (int k = 0; k < 4; k++) take_cmd("R9", mk(0, 0, 1, 1, 1, 'h300 + k), 1, 16'(16'h50 + k));
    take_cmd("R13", mk(1, 0, 1, 1, 1, 'h304), 0, 0);
    res_valid = 1'b1; res_data = 16'h54;
    @(negedge clk);
    chk("R13", !res_ready, res_ready, 0);
    push(2, mk(1, 0, 2, 2, 0, 'h77));
    pulse_trig(3'b100);
    quiet("R8", 6);
    chk("R13", !res_ready, res_ready, 0);
    pop_rq("R13", 1, 16'h50);
    chk("R13", res_ready, res_ready, 1);
    @(negedge clk); res_valid = 1'b0;
    take_cmd("R8", mk(1, 0, 2, 2, 0, 'h77), 0, 0);
    for (int k = 1; k < 5; k++) pop_rq("R9", 1, 16'(16'h50 + k));
    chk("R9", rq_empty == '1, rq_empty, 7);
    chk("R5", eoq_flag == 3'b101 && eoq_irq, {eoq_flag, eoq_irq}, 11);
    clr_eoq(0);
    chk("R12", eoq_flag == 3'b100 && eoq_irq, {eoq_flag, eoq_irq}, 9);
    clr_eoq(2);
    chk("R12", eoq_flag == 0 && !eoq_irq, {eoq_flag, eoq_irq}, 0);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule